// File: doc/BRIEF.md
# Indirect Address Pointer Unit

This block generates data-memory addresses for a small 8-bit controller with a 12-bit data space. It holds a set of 12-bit pointer registers. Each pointer can be read and written as two byte registers. It can also be used through a group of alias addresses, and the alias chosen decides how the effective address is formed and how the pointer changes. The core presents one decoded data address per cycle, together with a read or write strobe, the write byte and the working-register value. The block then does one of three things in that same cycle: it forwards an ordinary access to data memory, serves a pointer byte register, or resolves an alias into an effective address and a pointer update.

Two rules keep this safe when software uses pointers as stacks or table walkers. First, if an alias resolves onto another alias, the access is neutralised. Second, if an indirect write lands on a pointer's own byte register, the written value wins over that pointer's automatic step. The block drives no status flags, so pointer wrap to zero has no visible side effect.

Top module: `ind_ptr_unit`

## Requirements
- R1: Pointer n owns the eight addresses BASE+8n..BASE+8n+7, with BASE defaulting to FE0h. The offsets within that group mean: 0 plain, 1 post-increment, 2 post-decrement, 3 pre-increment, 4 indexed, 5 low byte (pointer bits 7:0), 6 high byte (pointer bits 11:8 in data bits 3:0), 7 ordinary memory. A direct read of a byte register returns that byte, and a direct write loads it. Neither asserts a memory strobe or changes anything else.
- R2: A plain alias access uses the pointer as the effective address and leaves the pointer unchanged.
- R3: Post-increment and post-decrement aliases use the current pointer as the address. The pointer then becomes pointer+1 or pointer-1 over all 12 bits, so carry and borrow cross between the bytes, and the result wraps modulo 4096.
- R4: A pre-increment alias uses pointer+1 (modulo 4096) as the address, and the pointer holds that value afterwards.
- R5: An indexed alias uses pointer + sign-extended working register (modulo 4096) as the address. The pointer is not modified.
- R6: When an alias resolves to any pointer's offset 0..4, a read returns 00h and asserts no memory strobe.
- R7: When an alias resolves to any pointer's offset 0..4, a write asserts no memory strobe and changes no pointer value apart from the accessing pointer's own mode update.
- R8: When an alias resolves to a byte register, a read returns that byte. A write loads that byte, and if the byte belongs to the accessing pointer, its automatic update is dropped. Neither case asserts a memory strobe.
- R9: Data bits 7:4 of a high-byte register read as zero, and writes to those bits are ignored.
- R10: All pointers reset to zero. Memory address, strobes and read data respond in the same cycle as the access, and pointer updates are visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_addr | input | 12 | Decoded data address of the current access |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_wdata | input | 8 | Write data |
| wreg | input | 8 | Working-register value used as signed index |
| mem_rdata | input | 8 | Data returned by memory |
| mem_addr | output | 12 | Effective address to memory |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Data to memory |
| rd_data | output | 8 | Read data returned to the core |

## Verification
The step modes are driven with pointer values at byte and space boundaries: 0FFh, 100h, FFFh and 000h. These values show whether a step covers all 12 bits or only the low byte, and whether the ends of the space wrap. The indexed mode is tried with working-register values 80h, 7Fh and a positive value that carries past FFFh, which separates signed from unsigned extension and confirms the modulo behaviour. Alias-on-alias reads and writes, and an alias write onto the accessing pointer's own low byte, check that memory strobes are suppressed and that the load takes priority over the step. A memory pattern that varies with the address confirms that the correct address reached memory.

// File: rtl/ind_ptr_pkg.sv
package ind_ptr_pkg;

   localparam int SLOT_BITS = 3;
   localparam int SLOTS_PER_PTR = 1 << SLOT_BITS;

   typedef enum logic [SLOT_BITS-1:0] {
      SLOT_PLAIN   = 3'd0,
      SLOT_POSTINC = 3'd1,
      SLOT_POSTDEC = 3'd2,
      SLOT_PREINC  = 3'd3,
      SLOT_INDEX   = 3'd4,
      SLOT_LO      = 3'd5,
      SLOT_HI      = 3'd6,
      SLOT_SPARE   = 3'd7
   } slot_e;

   function automatic logic slot_is_alias(slot_e s);
      return (s <= SLOT_INDEX);
   endfunction

   function automatic logic slot_is_byte(slot_e s);
      return (s == SLOT_LO) || (s == SLOT_HI);
   endfunction

endpackage

// File: rtl/ind_ptr_decode.sv
module ind_ptr_decode
   import ind_ptr_pkg::*;
#(
   parameter int AW    = 12,
   parameter int BASE  = 'hFE0,
   parameter int NPTR  = 3,
   parameter int IDX_W = 2
) (
   input  logic [AW-1:0]    addr,
   output logic             in_win,
   output logic [IDX_W-1:0] idx,
   output slot_e            slot
);

   localparam logic [AW-1:0] BASE_V = AW'(BASE);
   localparam logic [AW-1:0] WIN_V  = AW'(NPTR * SLOTS_PER_PTR);

   if (BASE % SLOTS_PER_PTR != 0) begin : g_bad_align
      $error("ind_ptr_decode: BASE must be a multiple of the slot group size");
   end
   if (BASE + NPTR * SLOTS_PER_PTR > (1 << AW)) begin : g_bad_fit
      $error("ind_ptr_decode: pointer window exceeds address space");
   end

   logic [AW-1:0] offset;

   always_comb begin
      offset = addr - BASE_V;
      in_win = (addr >= BASE_V) && (offset < WIN_V);
      slot   = slot_e'(offset[SLOT_BITS-1:0]);
      idx    = '0;
      for (int m = 0; m < NPTR; m++) begin
         if (offset[AW-1:SLOT_BITS] == (AW-SLOT_BITS)'(m)) idx = IDX_W'(m);
      end
   end

endmodule

// File: rtl/ind_ptr_ea.sv
module ind_ptr_ea
   import ind_ptr_pkg::*;
#(
   parameter int AW = 12,
   parameter int DW = 8
) (
   input  logic [AW-1:0] ptr,
   input  slot_e         slot,
   input  logic [DW-1:0] wreg,
   output logic [AW-1:0] ea,
   output logic [AW-1:0] nxt,
   output logic          step
);

   logic [AW-1:0] ptr_inc, ptr_dec, ptr_idx, wreg_ext;

   if (AW > DW) begin : g_sext
      assign wreg_ext = {{(AW-DW){wreg[DW-1]}}, wreg};
   end else begin : g_trunc
      assign wreg_ext = wreg[AW-1:0];
   end

   always_comb begin
      ptr_inc = ptr + AW'(1);
      ptr_dec = ptr - AW'(1);
      ptr_idx = ptr + wreg_ext;
      ea      = ptr;
      nxt     = ptr;
      step    = 1'b0;
      unique case (slot)
         SLOT_POSTINC: begin nxt = ptr_inc; step = 1'b1; end
         SLOT_POSTDEC: begin nxt = ptr_dec; step = 1'b1; end
         SLOT_PREINC:  begin ea = ptr_inc; nxt = ptr_inc; step = 1'b1; end
         SLOT_INDEX:   ea = ptr_idx;
         default:      ;
      endcase
   end

endmodule

// File: rtl/ind_ptr_reg.sv
module ind_ptr_reg #(
   parameter int AW = 12,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_lo,
   input  logic          ld_hi,
   input  logic [DW-1:0] wdata,
   input  logic          upd,
   input  logic [AW-1:0] nxt,
   output logic [AW-1:0] val
);

   localparam int HI_W = AW - DW;

   if (HI_W < 1 || HI_W > DW) begin : g_bad_width
      $error("ind_ptr_reg: AW must lie between DW+1 and 2*DW");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val <= '0;
      end else if (ld_lo || ld_hi) begin
         if (ld_lo) val[DW-1:0] <= wdata;
         if (ld_hi) val[AW-1:DW] <= wdata[HI_W-1:0];
      end else if (upd) begin
         val <= nxt;
      end
   end

   p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ld_lo |=> val[DW-1:0] == $past(wdata));

   p_hi_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_hi && !ld_lo) |=> (val[AW-1:DW] == $past(wdata[HI_W-1:0])) &&
                            (val[DW-1:0] == $past(val[DW-1:0])));

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_lo && !ld_hi && !upd) |=> val == $past(val));

   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !ld_lo && !ld_hi) |=> val == $past(nxt));

endmodule

// File: rtl/ind_ptr_unit.sv
module ind_ptr_unit
   import ind_ptr_pkg::*;
#(
   parameter int AW   = 12,
   parameter int DW   = 8,
   parameter int NPTR = 3,
   parameter int BASE = 'hFE0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [11:0]   acc_addr,
   input  logic          acc_rd,
   input  logic          acc_wr,
   input  logic [7:0]    acc_wdata,
   input  logic [7:0]    wreg,
   input  logic [7:0]    mem_rdata,
   output logic [11:0]   mem_addr,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [7:0]    mem_wdata,
   output logic [7:0]    rd_data
);

   localparam int IDX_W = (NPTR > 1) ? $clog2(NPTR) : 1;
   localparam int HI_W  = AW - DW;

   if (AW != 12 || DW != 8) begin : g_bad_port
      $error("ind_ptr_unit: port widths are fixed at 12-bit address, 8-bit data");
   end
   if (NPTR < 1) begin : g_bad_nptr
      $error("ind_ptr_unit: at least one pointer required");
   end

   logic [NPTR-1:0][AW-1:0] ptr_q;
   logic [NPTR-1:0]         ld_lo, ld_hi, upd;

   logic             access;
   logic             a_win, e_win;
   logic [IDX_W-1:0] a_idx, e_idx;
   slot_e            a_slot, e_slot;
   logic             a_alias, e_alias, e_byte;
   logic [AW-1:0]    a_ptr, e_ptr;
   logic [AW-1:0]    ea, nxt, eff;
   logic             step, mem_go;

   assign access = acc_rd | acc_wr;

   // Classify the presented address
   ind_ptr_decode #(.AW(AW), .BASE(BASE), .NPTR(NPTR), .IDX_W(IDX_W)) u_dec_acc (
      .addr   (acc_addr),
      .in_win (a_win),
      .idx    (a_idx),
      .slot   (a_slot)
   );

   assign a_alias = a_win & slot_is_alias(a_slot);

   always_comb begin
      a_ptr = '0;
      for (int m = 0; m < NPTR; m++) begin
         if (a_idx == IDX_W'(m)) a_ptr = ptr_q[m];
      end
   end

   ind_ptr_ea #(.AW(AW), .DW(DW)) u_ea (
      .ptr  (a_ptr),
      .slot (a_slot),
      .wreg (wreg),
      .ea   (ea),
      .nxt  (nxt),
      .step (step)
   );

   assign eff = a_alias ? ea : acc_addr;

   // Classify the effective address (catches alias-on-alias and pointer bytes)
   ind_ptr_decode #(.AW(AW), .BASE(BASE), .NPTR(NPTR), .IDX_W(IDX_W)) u_dec_eff (
      .addr   (eff),
      .in_win (e_win),
      .idx    (e_idx),
      .slot   (e_slot)
   );

   assign e_alias = e_win & slot_is_alias(e_slot);
   assign e_byte  = e_win & slot_is_byte(e_slot);
   assign mem_go  = ~e_alias & ~e_byte;

   always_comb begin
      e_ptr = '0;
      for (int m = 0; m < NPTR; m++) begin
         if (e_idx == IDX_W'(m)) e_ptr = ptr_q[m];
      end
   end

   assign mem_addr  = eff;
   assign mem_rd    = acc_rd & mem_go;
   assign mem_wr    = acc_wr & mem_go;
   assign mem_wdata = acc_wdata;

   always_comb begin
      if (e_alias)
         rd_data = '0;
      else if (e_byte)
         rd_data = (e_slot == SLOT_LO) ? e_ptr[DW-1:0]
                                       : {{(DW-HI_W){1'b0}}, e_ptr[AW-1:DW]};
      else
         rd_data = mem_rdata;
   end

   for (genvar g = 0; g < NPTR; g++) begin : g_ptr
      assign ld_lo[g] = acc_wr & e_byte & (e_idx == IDX_W'(g)) & (e_slot == SLOT_LO);
      assign ld_hi[g] = acc_wr & e_byte & (e_idx == IDX_W'(g)) & (e_slot == SLOT_HI);
      assign upd[g]   = access & a_alias & step & (a_idx == IDX_W'(g));

      ind_ptr_reg #(.AW(AW), .DW(DW)) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .ld_lo (ld_lo[g]),
         .ld_hi (ld_hi[g]),
         .wdata (acc_wdata),
         .upd   (upd[g]),
         .nxt   (nxt),
         .val   (ptr_q[g])
      );
   end

   p_byte_no_mem_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (access && a_win && slot_is_byte(a_slot)) |-> (!mem_rd && !mem_wr));

   p_alias_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && a_alias && e_alias) |-> (rd_data == '0 && !mem_rd));

   p_alias_write_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && a_alias && e_alias) |-> (!mem_wr && ld_lo == '0 && ld_hi == '0));

   p_preinc_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (access && a_alias && a_slot == SLOT_PREINC) |-> mem_addr == a_ptr + AW'(1));

   p_one_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(upd) <= 1);

endmodule

// File: tb/ind_ptr_unit_tb_top.sv
module ind_ptr_unit_tb_top;

   localparam int BASE = 'hFE0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] acc_addr = '0;
   logic        acc_rd = 1'b0, acc_wr = 1'b0;
   logic [7:0]  acc_wdata = '0, wreg = '0;
   logic [7:0]  mem_rdata;
   logic [11:0] mem_addr;
   logic        mem_rd, mem_wr;
   logic [7:0]  mem_wdata, rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [11:0] o_addr;
   logic        o_rd, o_wr;
   logic [7:0]  o_data, o_wdata;

   always #4 clk = ~clk;

   assign mem_rdata = mem_addr[7:0] ^ 8'h5A;

   ind_ptr_unit dut_i (
      .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_wr(acc_wr),
      .acc_wdata(acc_wdata), .wreg(wreg), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .rd_data(rd_data)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [11:0] slot_addr(input int n, input int off);
      return 12'(BASE + 8 * n + off);
   endfunction

   // one access: drive at falling edge, capture outputs, commit at rising edge
   task automatic acc(input logic [11:0] a, input logic rd, input logic wr,
                      input logic [7:0] wd, input logic [7:0] wr_reg);
      @(negedge clk);
      acc_addr = a; acc_rd = rd; acc_wr = wr; acc_wdata = wd; wreg = wr_reg;
      #1;
      o_addr = mem_addr; o_rd = mem_rd; o_wr = mem_wr; o_data = rd_data; o_wdata = mem_wdata;
      @(posedge clk);
      #1;
      acc_rd = 1'b0; acc_wr = 1'b0;
   endtask

   task automatic set_ptr(input int n, input logic [11:0] v);
      acc(slot_addr(n, 5), 1'b0, 1'b1, v[7:0], 8'h00);
      acc(slot_addr(n, 6), 1'b0, 1'b1, {4'h0, v[11:8]}, 8'h00);
   endtask

   task automatic get_ptr(input int n, output logic [11:0] v);
      logic [7:0] lo;
      acc(slot_addr(n, 5), 1'b1, 1'b0, 8'h00, 8'h00);
      lo = o_data;
      acc(slot_addr(n, 6), 1'b1, 1'b0, 8'h00, 8'h00);
      v = {o_data[3:0], lo};
   endtask

   task automatic t_reset;
      logic [11:0] v;
      for (int n = 0; n < 3; n++) begin
         get_ptr(n, v);
         check("R10", "pointer after reset", v, 0);
      end
   endtask

   task automatic t_direct;
      logic [11:0] v;
      set_ptr(0, 12'h123);
      check("R1", "byte write no mem strobe", o_wr, 0);
      get_ptr(0, v);
      check("R1", "pointer readback", v, 12'h123);
      check("R1", "byte read no mem strobe", o_rd, 0);
      acc(12'h050, 1'b0, 1'b1, 8'h77, 8'h00);
      check("R10", "ordinary write addr", o_addr, 12'h050);
      check("R10", "ordinary write strobe", o_wr, 1);
      check("R10", "ordinary write data", o_wdata, 8'h77);
      acc(slot_addr(0, 7), 1'b1, 1'b0, 8'h00, 8'h00);
      check("R1", "spare slot reaches memory", o_rd, 1);
   endtask

   task automatic t_plain;
      logic [11:0] v;
      set_ptr(0, 12'h123);
      acc(slot_addr(0, 0), 1'b1, 1'b0, 8'h00, 8'h00);
      check("R2", "plain address", o_addr, 12'h123);
      check("R2", "plain read data", o_data, 8'h23 ^ 8'h5A);
      get_ptr(0, v);
      check("R2", "plain leaves pointer", v, 12'h123);
   endtask

   task automatic t_step(input int off, input logic [11:0] start, input logic [11:0] exp_ea,
                         input logic [11:0] exp_ptr, input string req);
      logic [11:0] v;
      set_ptr(1, start);
      acc(slot_addr(1, off), 1'b1, 1'b0, 8'h00, 8'h00);
      check(req, "step address", o_addr, exp_ea);
      check(req, "step mem read", o_rd, 1);
      get_ptr(1, v);
      check(req, "step pointer", v, exp_ptr);
   endtask

   task automatic t_index(input logic [11:0] start, input logic [7:0] w, input logic [11:0] exp_ea);
      logic [11:0] v;
      set_ptr(2, start);
      acc(slot_addr(2, 4), 1'b0, 1'b1, 8'h33, w);
      check("R5", "indexed address", o_addr, exp_ea);
      check("R5", "indexed write strobe", o_wr, 1);
      get_ptr(2, v);
      check("R5", "indexed pointer kept", v, start);
   endtask

   task automatic t_alias_read;
      logic [11:0] v;
      set_ptr(1, slot_addr(0, 0));
      acc(slot_addr(1, 1), 1'b1, 1'b0, 8'h00, 8'h00);
      check("R6", "alias read data", o_data, 0);
      check("R6", "alias read strobe", o_rd, 0);
      get_ptr(1, v);
      check("R7", "own step still applies", v, slot_addr(0, 1));
   endtask

   task automatic t_alias_write;
      logic [11:0] v0, v1;
      set_ptr(0, 12'h456);
      set_ptr(1, slot_addr(1, 1));
      acc(slot_addr(1, 0), 1'b0, 1'b1, 8'hC3, 8'h00);
      check("R7", "alias write strobe", o_wr, 0);
      get_ptr(0, v0);
      get_ptr(1, v1);
      check("R7", "other pointer untouched", v0, 12'h456);
      check("R7", "own pointer untouched", v1, slot_addr(1, 1));
   endtask

   task automatic t_write_wins;
      logic [11:0] v;
      set_ptr(2, slot_addr(2, 5));
      acc(slot_addr(2, 1), 1'b0, 1'b1, 8'h42, 8'h00);
      check("R8", "byte write no mem strobe", o_wr, 0);
      get_ptr(2, v);
      check("R8", "write beats post-increment", v, {slot_addr(2, 5) >> 8, 8'h42});
      set_ptr(0, 12'h3AB);
      set_ptr(1, slot_addr(0, 5));
      acc(slot_addr(1, 0), 1'b1, 1'b0, 8'h00, 8'h00);
      check("R8", "indirect byte read", o_data, 8'hAB);
      check("R8", "indirect byte read strobe", o_rd, 0);
   endtask

   task automatic t_hi_mask;
      acc(slot_addr(0, 6), 1'b0, 1'b1, 8'hFF, 8'h00);
      acc(slot_addr(0, 6), 1'b1, 1'b0, 8'h00, 8'h00);
      check("R9", "high byte upper bits", o_data, 8'h0F);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_direct();
      t_plain();
      t_step(1, 12'h0FF, 12'h0FF, 12'h100, "R3");
      t_step(2, 12'h100, 12'h100, 12'h0FF, "R3");
      t_step(1, 12'hFFF, 12'hFFF, 12'h000, "R3");
      t_step(2, 12'h000, 12'h000, 12'hFFF, "R3");
      t_step(3, 12'h0FF, 12'h100, 12'h100, "R4");
      t_step(3, 12'hFFF, 12'h000, 12'h000, "R4");
      t_index(12'h200, 8'h80, 12'h180);
      t_index(12'h200, 8'h7F, 12'h27F);
      t_index(12'hFF0, 8'h20, 12'h010);
      t_alias_read();
      t_alias_write();
      t_write_wins();
      t_hi_mask();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule